// File: doc/BRIEF.md
# Disable Pulse-Width Discriminator

This block watches one synchronous digital level that is high whenever a shared control pin sits above its disable threshold. It measures how many consecutive clock cycles the level stays high. A pulse whose width falls inside a narrow window is read as an error-clear command, and the block then issues a single-cycle strobe. A hold that reaches the shutdown length is read as a disable command, and the block drives a level output that turns off every gate driver for as long as the hold lasts. Any other pulse width does nothing.

A second flag, which shows that the same pin sits in its low voltage range, is passed on as a bypass indication. Downstream logic uses it to skip dead-time insertion and to allow both switches of a half bridge on together. The indication is blocked while the disable level is high or a shutdown is in force. Voltage-range detection happens upstream. Both inputs arrive already thresholded and synchronous to `clk`.

At the default 100 MHz timing, the clear window spans 310 to 340 high cycles and shutdown begins at 700. All three limits are parameters. When a shutdown hold is released, the block also issues the clear strobe, because disabling the driver resets its latched short-circuit errors.

Top module: `dis_pulse_discriminator`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it, `err_clr_o` and `shut_o` are 0 and any width count in progress is discarded.
- R2: A run of N consecutive high samples of `dis_lvl_i`, with CLR_LO (310) <= N <= CLR_HI (340), followed by a low sample, raises `err_clr_o` in the cycle after the clock edge that sampled the low.
- R3: A run of fewer than CLR_LO high samples produces no `err_clr_o` pulse and no `shut_o`.
- R4: A run of CLR_HI+1 (341) up to SHUT_AT-1 (699) high samples produces no `err_clr_o` pulse and no `shut_o`.
- R5: `shut_o` rises right after the edge that takes the SHUT_AT-th (700th) consecutive high sample. It stays high while `dis_lvl_i` stays high and drops right after the first edge that samples `dis_lvl_i` low.
- R6: The width count saturates at SHUT_AT and never wraps, so `shut_o` stays high for a hold of any length, including one longer than the counter's binary range.
- R7: Releasing a hold that reached SHUT_AT raises `err_clr_o` in the same cycle that `shut_o` drops.
- R8: `bypass_o` is 1 exactly when `low_rng_i` is 1, `dis_lvl_i` is 0 and `shut_o` is 0.
- R9: Every `err_clr_o` pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dis_lvl_i | input | 1 | Pin above the disable threshold, active high |
| low_rng_i | input | 1 | Pin in its low range |
| err_clr_o | output | 1 | One-cycle error-clear strobe |
| shut_o | output | 1 | Shut down all gate outputs while high |
| bypass_o | output | 1 | Dead-time bypass indication |

## Verification
The strobe comes from a register. It is therefore due one cycle after the edge that samples the falling level, and the bench reads it at the falling clock edge that follows, then again one cycle later to confirm it has cleared. `shut_o` is decoded straight from the saturating count. It therefore changes right after the edge that takes the 700th high sample and right after the edge that takes the first low sample, and the bench probes it at the 699th and 700th half-period marks. `bypass_o` is combinational and is read half a cycle after its inputs change. Each width class is tested at both of its limits, one sample inside and one sample outside.

// File: rtl/dpwd_pkg.sv
`timescale 1ns/1ps
package dpwd_pkg;

    // default cycle limits for a 100 MHz clock
    parameter int unsigned CLR_LO_DEF  = 310;
    parameter int unsigned CLR_HI_DEF  = 340;
    parameter int unsigned SHUT_AT_DEF = 700;

    // action decided at the end of a high run
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_CLEAR   = 2'd1,
        ACT_RELEASE = 2'd2
    } end_act_e;

    // information about the run presented to the classifier
    typedef struct packed {
        logic ending;   // level sampled low after a high run
        logic full;     // run reached the shutdown length
    } run_state_t;

    function automatic int unsigned sat_next(input int unsigned cur,
                                             input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

    function automatic logic in_window(input int unsigned val,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/dpwd_run_counter.sv
`timescale 1ns/1ps
module dpwd_run_counter
    import dpwd_pkg::*;
#(
    parameter int unsigned LIM = SHUT_AT_DEF,
    parameter int unsigned W   = $clog2(LIM + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         level_i,
    output logic [W-1:0] cnt_o,
    output run_state_t   st_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (level_i) begin
            cnt_q <= W'(sat_next(int'(cnt_q), LIM));
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        st_o.ending = !level_i && (cnt_q != '0);
        st_o.full   = (int'(cnt_q) >= LIM);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/dpwd_width_class.sv
`timescale 1ns/1ps
module dpwd_width_class
    import dpwd_pkg::*;
#(
    parameter int unsigned LO  = CLR_LO_DEF,
    parameter int unsigned HI  = CLR_HI_DEF,
    parameter int unsigned LIM = SHUT_AT_DEF,
    parameter int unsigned W   = $clog2(LIM + 1)
) (
    input  logic [W-1:0] cnt_i,
    input  run_state_t   st_i,
    output end_act_e     act_o
);

    always_comb begin
        act_o = ACT_NONE;
        if (st_i.ending) begin
            if (st_i.full) begin
                act_o = ACT_RELEASE;
            end else if (in_window(int'(cnt_i), LO, HI)) begin
                act_o = ACT_CLEAR;
            end
        end
    end

endmodule

// File: rtl/dpwd_strobe_gen.sv
`timescale 1ns/1ps
module dpwd_strobe_gen
    import dpwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  end_act_e act_i,
    output logic     strobe_o
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= (act_i == ACT_CLEAR) || (act_i == ACT_RELEASE);
        end
    end

    assign strobe_o = strobe_q;

endmodule

// File: rtl/dis_pulse_discriminator.sv
`timescale 1ns/1ps
module dis_pulse_discriminator
    import dpwd_pkg::*;
#(
    parameter int unsigned CLR_LO  = CLR_LO_DEF,
    parameter int unsigned CLR_HI  = CLR_HI_DEF,
    parameter int unsigned SHUT_AT = SHUT_AT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic dis_lvl_i,
    input  logic low_rng_i,
    output logic err_clr_o,
    output logic shut_o,
    output logic bypass_o
);

    localparam int unsigned CNT_W = $clog2(SHUT_AT + 1);

    logic [CNT_W-1:0] run_cnt;
    run_state_t       run_st;
    end_act_e         end_act;

    dpwd_run_counter #(
        .LIM (SHUT_AT),
        .W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .level_i (dis_lvl_i),
        .cnt_o   (run_cnt),
        .st_o    (run_st)
    );

    dpwd_width_class #(
        .LO  (CLR_LO),
        .HI  (CLR_HI),
        .LIM (SHUT_AT),
        .W   (CNT_W)
    ) u_cls (
        .cnt_i (run_cnt),
        .st_i  (run_st),
        .act_o (end_act)
    );

    dpwd_strobe_gen u_stb (
        .clk      (clk),
        .rst      (rst),
        .act_i    (end_act),
        .strobe_o (err_clr_o)
    );

    assign shut_o   = run_st.full;
    assign bypass_o = low_rng_i && !dis_lvl_i && !run_st.full;

endmodule

// File: rtl/dpwd_checker.sv
`timescale 1ns/1ps
module dpwd_checker #(
    parameter int unsigned LO  = 310,
    parameter int unsigned HI  = 340,
    parameter int unsigned LIM = 700
) (
    input logic clk,
    input logic rst,
    input logic dis_lvl_i,
    input logic low_rng_i,
    input logic err_clr_o,
    input logic shut_o,
    input logic bypass_o
);

    // independent length of the current high run, saturating
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= 0;
        else if (dis_lvl_i) run_q <= (run_q >= LIM) ? LIM : run_q + 1;
        else                run_q <= 0;
    end

    logic run_end;
    assign run_end = !dis_lvl_i && (run_q != 0);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!err_clr_o && !shut_o));

    p_clear_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        (run_end && run_q >= LO && run_q <= HI) |=> err_clr_o);

    p_quiet_short_r3: assert property (@(posedge clk) disable iff (rst)
        (run_end && run_q < LO) |=> !err_clr_o);

    p_quiet_middle_r4: assert property (@(posedge clk) disable iff (rst)
        (run_end && run_q > HI && run_q < LIM) |=> !err_clr_o);

    p_shut_len_r5: assert property (@(posedge clk) disable iff (rst)
        shut_o == (run_q >= LIM));

    p_shut_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !dis_lvl_i |=> !shut_o);

    p_shut_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (shut_o && dis_lvl_i) |=> shut_o);

    p_release_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (shut_o && !dis_lvl_i) |=> err_clr_o);

    p_bypass_on_r8: assert property (@(posedge clk) disable iff (rst)
        (low_rng_i && !dis_lvl_i && !shut_o) |-> bypass_o);

    p_bypass_off_r8: assert property (@(posedge clk) disable iff (rst)
        (dis_lvl_i || shut_o) |-> !bypass_o);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        err_clr_o |=> !err_clr_o);

endmodule

bind dis_pulse_discriminator dpwd_checker #(
    .LO  (CLR_LO),
    .HI  (CLR_HI),
    .LIM (SHUT_AT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dis_lvl_i (dis_lvl_i),
    .low_rng_i (low_rng_i),
    .err_clr_o (err_clr_o),
    .shut_o    (shut_o),
    .bypass_o  (bypass_o)
);

// File: tb/dis_pulse_discriminator_tb.sv
`timescale 1ns/1ps
module dis_pulse_discriminator_tb;

    localparam int unsigned LO  = 310;
    localparam int unsigned HI  = 340;
    localparam int unsigned LIM = 700;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b0;
    logic lowr = 1'b0;
    logic clr, shut, byp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dis_pulse_discriminator #(
        .CLR_LO  (LO),
        .CLR_HI  (HI),
        .SHUT_AT (LIM)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .dis_lvl_i (dis),
        .low_rng_i (lowr),
        .err_clr_o (clr),
        .shut_o    (shut),
        .bypass_o  (byp)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1; dis = 1'b0; lowr = 1'b0;
        idle(3);
        chk("R1 clr in reset", clr, 1'b0);
        chk("R1 shut in reset", shut, 1'b0);
        rst = 1'b0;
        idle(1);
        chk("R1 clr after reset", clr, 1'b0);
        chk("R1 shut after reset", shut, 1'b0);
    endtask

    // pulse of w high samples, below the shutdown length
    task automatic t_pulse(input int w, input logic exp_clr, input string req);
        dis = 1'b1;
        idle(w);
        chk({req, " no shut during pulse"}, shut, 1'b0);
        dis = 1'b0;
        idle(1);
        chk({req, " strobe after fall"}, clr, exp_clr);
        chk({req, " no shut after fall"}, shut, 1'b0);
        idle(1);
        chk("R9 strobe one cycle", clr, 1'b0);
        idle(4);
    endtask

    // long hold of w >= LIM samples
    task automatic t_hold(input int w, input string req);
        dis = 1'b1;
        idle(LIM - 1);
        chk("R5 shut still low at 699", shut, 1'b0);
        idle(1);
        chk("R5 shut high at 700", shut, 1'b1);
        chk("R5 no strobe while held", clr, 1'b0);
        for (int i = LIM; i < w; i += 100) begin
            idle((w - i) < 100 ? (w - i) : 100);
            chk({req, " shut stays high"}, shut, 1'b1);
        end
        dis = 1'b0;
        idle(1);
        chk("R5 shut drops after fall", shut, 1'b0);
        chk("R7 strobe on release", clr, 1'b1);
        idle(1);
        chk("R9 release strobe one cycle", clr, 1'b0);
        idle(4);
    endtask

    // R1: reset in the middle of a run discards the earlier samples
    task automatic t_reset_mid();
        dis = 1'b1;
        idle(200);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        idle(320);
        dis = 1'b0;
        idle(1);
        chk("R1 reset restarts count (320 after reset)", clr, 1'b1);
        idle(5);
    endtask

    // R8: bypass indication
    task automatic t_bypass();
        lowr = 1'b1; dis = 1'b0;
        #1;
        chk("R8 bypass when low range", byp, 1'b1);
        idle(1);
        lowr = 1'b0;
        #1;
        chk("R8 no bypass without low range", byp, 1'b0);
        idle(1);
        lowr = 1'b1; dis = 1'b1;
        #1;
        chk("R8 no bypass while disable level", byp, 1'b0);
        idle(LIM);
        chk("R8 shut active", shut, 1'b1);
        dis = 1'b0;
        #1;
        chk("R8 no bypass while shut lingers", byp, 1'b0);
        idle(1);
        chk("R8 bypass back after release", byp, 1'b1);
        lowr = 1'b0;
        idle(4);
    endtask

    initial begin
        t_reset();
        t_pulse(1,        1'b0, "R3 width 1");
        t_pulse(LO - 1,   1'b0, "R3 width 309");
        t_pulse(LO,       1'b1, "R2 width 310");
        t_pulse(325,      1'b1, "R2 width 325");
        t_pulse(HI,       1'b1, "R2 width 340");
        t_pulse(HI + 1,   1'b0, "R4 width 341");
        t_pulse(LIM - 1,  1'b0, "R4 width 699");
        t_hold(LIM + 20,  "R5");
        t_hold(2500,      "R6");
        t_reset_mid();
        t_bypass();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule